// File: doc/BRIEF.md
# Sequential Radix-2 Booth Multiplier

This block forms the signed product of two WIDTH-bit two's-complement operands. It uses radix-2 Booth recoding over a fixed run of WIDTH clock cycles. A start pulse, taken while the block is idle, latches the multiplicand and the multiplier. The same pulse clears the running accumulator and the appended low bit.

On every following cycle the block looks at the lowest multiplier bit together with the appended bit. From that pair it adds the multiplicand into the accumulator, subtracts the multiplicand from it, or leaves it alone. In the same cycle it shifts the accumulator, the multiplier and the appended bit right by one place as one arithmetic unit.

The adder is WIDTH bits wide. Any overflow out of it is discarded. The shift instead takes the true sign of the full-precision sum, so the most negative multiplicand still gives an exact result. After the last step the 2*WIDTH-bit product is registered and a one-cycle completion pulse is raised.

Top module: `booth_mult`

## Requirements
- R1: While reset is high and in the first cycle after it, busy and done are 0 and product is all zeros.
- R2: Start is accepted on a clock edge where busy is 0. Busy is 1 from the next cycle on. Done is 1 exactly WIDTH cycles after the accepting edge, and busy is 0 in that same cycle.
- R3: When done is 1, product equals the signed product of the multiplicand and the multiplier that were present at the accepting edge. Both operands are read as two's-complement and the product is a 2*WIDTH-bit two's-complement value.
- R4: The most negative operand value -2^(WIDTH-1) gives exact results in either operand position. This includes (-2^(WIDTH-1)) * (-2^(WIDTH-1)) = 2^(2*WIDTH-2).
- R5: Done is high for exactly one cycle per accepted operation.
- R6: While busy is 1, start and operand changes are ignored. The running operation keeps its result and its timing, and busy stays 1 until the operation completes.
- R7: Product changes only in a cycle where done is 1. Between completions it holds its last value.
- R8: Start given in the same cycle that done is 1 is accepted. A new operation then begins with no idle cycle in between.
- R9: A zero multiplicand or a zero multiplier gives a product of zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a multiplication when idle |
| multiplicand | input | WIDTH | Signed multiplicand, sampled at acceptance |
| multiplier | input | WIDTH | Signed multiplier, sampled at acceptance |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse: product is valid and updated |
| product | output | 2*WIDTH | Signed product, held until the next completion |

## Verification
Completion of one operation and acceptance of the next can fall in the same cycle. The done pulse clears busy, and a start that is waiting is taken on that very edge. The bench provokes this by issuing operations back to back. Its driver waits only for busy to drop, so each new start lands in the cycle where done is raised. The scoreboard then judges both operations: each product must match its own operands, and each completion must come exactly WIDTH cycles after its own accepting edge. An overlap that was wrongly handled would therefore show up as a wrong product or as a shifted done cycle.

// File: rtl/booth_pkg.sv
`timescale 1ns/1ps
package booth_pkg;
  typedef enum logic [1:0] {
    OP_SKIP = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2
  } booth_op_e;
endpackage

// File: rtl/booth_pair_decode.sv
`timescale 1ns/1ps
module booth_pair_decode
  import booth_pkg::*;
(
  input  logic      q_lsb,
  input  logic      q_app,
  output booth_op_e op
);
  always_comb begin
    unique case ({q_lsb, q_app})
      2'b01:   op = OP_ADD;
      2'b10:   op = OP_SUB;
      default: op = OP_SKIP;
    endcase
  end
endmodule

// File: rtl/booth_addsub.sv
`timescale 1ns/1ps
module booth_addsub
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] mcand,
  input  booth_op_e        op,
  output logic [WIDTH-1:0] sum,
  output logic             true_sign
);
  logic [WIDTH-1:0] operand;
  logic             carry_in;
  logic [WIDTH:0]   full;

  always_comb begin
    unique case (op)
      OP_ADD:  operand = mcand;
      OP_SUB:  operand = ~mcand;
      default: operand = '0;
    endcase
    carry_in = (op == OP_SUB);
  end

  assign full = {1'b0, acc} + {1'b0, operand} + {{WIDTH{1'b0}}, carry_in};
  assign sum  = full[WIDTH-1:0];
  // sign of the (WIDTH+1)-bit sign-extended sum; the carry out itself is dropped
  assign true_sign = acc[WIDTH-1] ^ operand[WIDTH-1] ^ full[WIDTH];
endmodule

// File: rtl/booth_seq_ctrl.sv
`timescale 1ns/1ps
module booth_seq_ctrl #(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic load,
  output logic step,
  output logic last
);
  localparam int CNT_W = $clog2(WIDTH + 1);

  logic [CNT_W-1:0] remaining;

  assign load = start && !busy;
  assign step = busy;
  assign last = busy && (remaining == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      remaining <= '0;
    end else if (load) begin
      busy      <= 1'b1;
      remaining <= CNT_W'(WIDTH);
    end else if (step) begin
      remaining <= remaining - CNT_W'(1);
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/booth_mult.sv
`timescale 1ns/1ps
module booth_mult
  import booth_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic [WIDTH-1:0]   multiplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  logic [WIDTH-1:0] acc_q;
  logic [WIDTH-1:0] mq_q;
  logic [WIDTH-1:0] mcand_q;
  logic             app_q;
  logic             load, step, last;
  booth_op_e        op;
  logic [WIDTH-1:0] sum;
  logic             true_sign;
  logic [WIDTH-1:0] acc_next;
  logic [WIDTH-1:0] mq_next;

  booth_seq_ctrl #(.WIDTH(WIDTH)) i_ctrl (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .busy (busy),
    .load (load),
    .step (step),
    .last (last)
  );

  booth_pair_decode i_dec (
    .q_lsb(mq_q[0]),
    .q_app(app_q),
    .op   (op)
  );

  booth_addsub #(.WIDTH(WIDTH)) i_addsub (
    .acc      (acc_q),
    .mcand    (mcand_q),
    .op       (op),
    .sum      (sum),
    .true_sign(true_sign)
  );

  assign acc_next = {true_sign, sum[WIDTH-1:1]};
  assign mq_next  = {sum[0], mq_q[WIDTH-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      mq_q    <= '0;
      mcand_q <= '0;
      app_q   <= 1'b0;
      product <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load) begin
        mcand_q <= multiplicand;
        mq_q    <= multiplier;
        acc_q   <= '0;
        app_q   <= 1'b0;
      end else if (step) begin
        acc_q <= acc_next;
        mq_q  <= mq_next;
        app_q <= mq_q[0];
        if (last) begin
          product <= {acc_next, mq_next};
          done    <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/booth_mult_chk.sv
`timescale 1ns/1ps
module booth_mult_chk #(
  parameter int WIDTH = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               start,
  input logic [WIDTH-1:0]   multiplicand,
  input logic [WIDTH-1:0]   multiplier,
  input logic               busy,
  input logic               done,
  input logic [2*WIDTH-1:0] product
);
  logic [WIDTH-1:0]   cap_mc, cap_mp;
  int                 lat;
  logic [2*WIDTH-1:0] exp_prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      cap_mc <= '0;
      cap_mp <= '0;
      lat    <= 0;
    end else if (start && !busy) begin
      cap_mc <= multiplicand;
      cap_mp <= multiplier;
      lat    <= 0;
    end else if (busy) begin
      lat <= lat + 1;
    end
  end

  assign exp_prod = $signed({{WIDTH{cap_mc[WIDTH-1]}}, cap_mc}) *
                    $signed({{WIDTH{cap_mp[WIDTH-1]}}, cap_mp});

  p_busy_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> (lat == WIDTH));
  p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  p_result_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (product == exp_prod));
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && lat != WIDTH - 1) |=> busy);
  p_hold_product_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(product));
endmodule

bind booth_mult booth_mult_chk #(.WIDTH(WIDTH)) i_chk (.*);

// File: tb/test_booth_mult.sv
`timescale 1ns/1ps
module test_booth_mult;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           start = 1'b0;
  logic [W-1:0]   mc = '0;
  logic [W-1:0]   mp = '0;
  logic           busy, done;
  logic [2*W-1:0] product;

  booth_mult #(.WIDTH(W)) i_booth_mult (
    .clk(clk), .rst(rst), .start(start),
    .multiplicand(mc), .multiplier(mp),
    .busy(busy), .done(done), .product(product)
  );

  always #2.5 clk = ~clk;

  int     checks = 0;
  int     fails = 0;
  longint cyc = 0;
  bit     finished = 0;
  int     overlap_starts = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    logic [2*W-1:0] prod;
    longint         due;
    string          tag;
  } exp_t;

  exp_t           sb[$];
  logic [2*W-1:0] last_prod = '0;
  logic           prev_done = 1'b0;

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [2*W-1:0] sa, sbv;
    sa  = {{W{a[W-1]}}, a};
    sbv = {{W{b[W-1]}}, b};
    return sa * sbv;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic do_op(input logic [W-1:0] a, input logic [W-1:0] b, input string tag);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    if (done) overlap_starts++;
    mc    = a;
    mp    = b;
    start = 1'b1;
    e.prod = ref_mul(a, b);
    e.due  = cyc + 1 + W;
    e.tag  = tag;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic poke_busy(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    check(busy == 1'b1, "R6", "busy before ignored start", longint'(busy), 1);
    mc    = a;
    mp    = b;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    mc    = ~a;
    check(busy == 1'b1, "R6", "busy after ignored start", longint'(busy), 1);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && !finished) begin
      if (done) begin
        check(!prev_done, "R5", "done longer than one cycle", 1, 0);
        check(!busy, "R2", "busy while done", longint'(busy), 0);
        if (sb.size() == 0) begin
          check(1'b0, "R5", "done with nothing pending", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          check(product == e.prod, e.tag, "product", longint'(product), longint'(e.prod));
          check(cyc == e.due, "R2", "done cycle", cyc, e.due);
        end
        last_prod = product;
      end else begin
        check(product === last_prod, "R7", "product held", longint'(product), longint'(last_prod));
      end
      prev_done = done;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(busy == 1'b0, "R1", "busy in reset", longint'(busy), 0);
    check(done == 1'b0, "R1", "done in reset", longint'(done), 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", longint'(busy), 0);
    check(done == 1'b0, "R1", "done after reset", longint'(done), 0);
    check(product == '0, "R1", "product after reset", longint'(product), 0);

    do_op(8'd3,   8'd5,   "R3");
    do_op(-8'sd3, 8'd7,   "R3");
    do_op(8'hFF,  8'hFF,  "R3");
    do_op(8'h55,  8'hAA,  "R3");
    do_op(8'h80,  8'h80,  "R4");
    do_op(8'h80,  8'h7F,  "R4");
    do_op(8'h7F,  8'h80,  "R4");
    do_op(8'h80,  8'h01,  "R4");
    do_op(8'h01,  8'h80,  "R4");
    do_op(8'h00,  8'hB3,  "R9");
    do_op(8'h37,  8'h00,  "R9");

    // R6: start and operand changes during a run are ignored
    do_op(8'd100, -8'sd9, "R6");
    poke_busy(8'h80, 8'h80);
    poke_busy(8'h11, 8'h22);

    // R8: back-to-back, each new start lands on the done cycle
    for (int i = 0; i < 6; i++) do_op(W'(i * 37 + 5), W'(8'hF0 - i * 13), "R8");

    for (int i = 0; i < 200; i++) do_op(W'($urandom()), W'($urandom()), "R3");

    while (sb.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R5", "pending results", sb.size(), 0);
    check(overlap_starts > 0, "R8", "starts taken on done cycle", overlap_starts, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule